// File: doc/BRIEF.md
# Event timer register file and main counter

This block is the software-visible register file of a multi-channel event timer, together with its free-running 64-bit main counter. A host reaches it through a simple 32-bit word bus: a write strobe, an address and write data, with read data driven combinationally from the address. It holds a constant capability word, a global configuration word (run and legacy-route bits), a per-channel interrupt status word and the main counter. It also holds one register group per channel with configuration, comparator and message-route words.

The counter counts one step per clock only while the global run bit is set. Clearing the bit freezes the count and drops the armed flag of every channel. Setting the bit again resumes counting from the frozen value and arms each channel whose comparator has been programmed, meaning it is no longer all ones. The comparator, match and interrupt-delivery logic are neighbours. They take the channel configuration, comparator, route and armed flags from this block's outputs, and they report matches back on `evt_hit`.

Top module: `evtmr_regblk`

## Requirements
- R1: The word at 0x000 reads 0x8086A001 with the channel count minus one placed in bits 12:8 (0x8086A201 for three channels). The word at 0x004 reads the tick period in femtoseconds (parameter `TICK_FS`).
- R2: The channel count is the parameter `N_CH` clamped to 3..32. Channel groups start at 0x100 with a 0x20 stride. An access to a group at or beyond the clamped count reads 0, and a write to it changes nothing.
- R3: The global configuration word at 0x010 has bit 0 (run) and bit 1 (legacy route), both 0 after reset. All other bits read 0. `ctr_run` and `legacy_on` mirror bits 0 and 1.
- R4: While run is 1 the counter at 0x0F0 (low) / 0x0F4 (high) rises by exactly 1 per clock, carrying from the low into the high half. While run is 0 it holds its value.
- R5: A write to a counter half replaces that half only while run is 0. While run is 1 such a write is ignored and counting continues.
- R6: Setting run after a halt resumes counting from the frozen value.
- R7: A channel configuration low word (group +0x00) resets to 0x30. A write changes only the bits in mask 0x7F4E and keeps all other bits. The high word (+0x04) always reads parameter `ROUTE_CAP`, and writes to it are ignored.
- R8: A comparator (+0x08 low, +0x0C high) resets to all ones, and each half is writable. Any comparator write clears configuration bit 6. While configuration bit 8 (32-bit mode) is 1, the comparator high half is 0 and writes to it are ignored.
- R9: The route words (+0x10 low, +0x14 high) reset to 0 and read back what was written. They are also driven on `ch_route`.
- R10: On a write that takes run from 0 to 1, each channel whose comparator is not all ones becomes armed, and every other channel stays unarmed.
- R11: While run is 0 no channel is armed, and taking run to 0 disarms all channels. While run is 1, a comparator write arms its channel. Raising configuration bit 2 (channel enable) also arms the channel, and lowering bit 2 disarms it.
- R12: The status word at 0x020 sets bit i when `evt_hit[i]` is 1. Writing 1 to bit i clears it, and writing 0 leaves it. A hit in the same cycle as the clear keeps the bit set.
- R13: Unmapped offsets and addresses not on a 4-byte boundary read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 12 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_hit | input | NT | Per-channel match pulses from the comparators |
| ctr_val | output | 64 | Main counter value |
| ctr_run | output | 1 | Global run bit |
| legacy_on | output | 1 | Legacy route bit |
| ch_armed | output | NT | Per-channel armed flags |
| irq_sts | output | NT | Interrupt status bits |
| ch_cfg | output | NT*32 | Channel configuration low words, channel 0 in the low bits |
| ch_cmp | output | NT*64 | Channel comparators |
| ch_route | output | NT*64 | Channel route words |

## Verification
The assertions check on every cycle that the count steps by one while running and holds while halted. They also check that no channel is ever armed while halted, that bits outside the channel write mask never change, that the comparator high half stays zero in 32-bit mode, and how status bits set and clear. The bench scenarios cover the rest: the decoded addresses and read-back values, the clamped channel count, which channels arm on a run edge, resume from the frozen count, and writes to the counter that are ignored while it runs. These depend on sequences of bus accesses, not on one cycle's relations.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
    localparam int ADDR_W = 12;
    localparam int CTR_W  = 64;
    localparam int CH_MIN = 3;
    localparam int CH_MAX = 32;

    localparam logic [31:0] CAP_LO_BASE = 32'h8086_A001;
    localparam int          CAP_NUM_LSB = 8;

    localparam logic [ADDR_W-1:0] A_CAP_LO   = 12'h000;
    localparam logic [ADDR_W-1:0] A_CAP_HI   = 12'h004;
    localparam logic [ADDR_W-1:0] A_GCFG     = 12'h010;
    localparam logic [ADDR_W-1:0] A_ISR      = 12'h020;
    localparam logic [ADDR_W-1:0] A_CTR_LO   = 12'h0F0;
    localparam logic [ADDR_W-1:0] A_CTR_HI   = 12'h0F4;
    localparam logic [ADDR_W-1:0] A_GRP_BASE = 12'h100;
    localparam int                GRP_SHIFT  = 5;

    localparam logic [4:0] G_CFG_LO = 5'h00;
    localparam logic [4:0] G_CFG_HI = 5'h04;
    localparam logic [4:0] G_CMP_LO = 5'h08;
    localparam logic [4:0] G_CMP_HI = 5'h0C;
    localparam logic [4:0] G_RT_LO  = 5'h10;
    localparam logic [4:0] G_RT_HI  = 5'h14;

    localparam logic [31:0] CH_CFG_WMASK = 32'h0000_7F4E;
    localparam logic [31:0] CH_CFG_RST   = 32'h0000_0030;
    localparam int CHB_ENA    = 2;
    localparam int CHB_SETVAL = 6;
    localparam int CHB_M32    = 8;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_CAP_LO, REG_CAP_HI, REG_GCFG, REG_ISR, REG_CTR_LO, REG_CTR_HI,
        REG_CH_CFG_LO, REG_CH_CFG_HI, REG_CH_CMP_LO, REG_CH_CMP_HI,
        REG_CH_RT_LO, REG_CH_RT_HI
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [4:0] ch;
    } dec_t;

    function automatic int clamp_ch(input int n);
        if (n < CH_MIN)      return CH_MIN;
        else if (n > CH_MAX) return CH_MAX;
        else                 return n;
    endfunction
endpackage

// File: rtl/evt_addr_dec.sv
`timescale 1ns/1ps
module evt_addr_dec import evt_pkg::*; #(
    parameter int NT = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int GRP_SPAN = NT * (1 << GRP_SHIFT);

    logic [ADDR_W-1:0] rel;
    logic              in_grp;

    always_comb begin
        rel     = addr - A_GRP_BASE;
        in_grp  = (addr >= A_GRP_BASE) && (32'(rel) < GRP_SPAN);
        dec.sel = REG_NONE;
        dec.ch  = rel[GRP_SHIFT +: 5];
        if (addr[1:0] == 2'b00) begin
            if (in_grp) begin
                case (rel[4:0])
                    G_CFG_LO: dec.sel = REG_CH_CFG_LO;
                    G_CFG_HI: dec.sel = REG_CH_CFG_HI;
                    G_CMP_LO: dec.sel = REG_CH_CMP_LO;
                    G_CMP_HI: dec.sel = REG_CH_CMP_HI;
                    G_RT_LO:  dec.sel = REG_CH_RT_LO;
                    G_RT_HI:  dec.sel = REG_CH_RT_HI;
                    default:  dec.sel = REG_NONE;
                endcase
            end else begin
                case (addr)
                    A_CAP_LO: dec.sel = REG_CAP_LO;
                    A_CAP_HI: dec.sel = REG_CAP_HI;
                    A_GCFG:   dec.sel = REG_GCFG;
                    A_ISR:    dec.sel = REG_ISR;
                    A_CTR_LO: dec.sel = REG_CTR_LO;
                    A_CTR_HI: dec.sel = REG_CTR_HI;
                    default:  dec.sel = REG_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/evt_main_ctr.sv
`timescale 1ns/1ps
module evt_main_ctr import evt_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    output logic [CTR_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (run)   cnt <= cnt + 1'b1;
        else if (wr_lo) cnt[31:0] <= wdata;
        else if (wr_hi) cnt[CTR_W-1:32] <= wdata;
    end

    // R4: one step per clock while running
    p_tick_r4: assert property (@(posedge clk) disable iff (rst)
        run |=> (cnt == $past(cnt) + 64'd1));

    // R4: frozen while halted and not written
    p_halt_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt));
endmodule

// File: rtl/evt_chan_regs.sv
`timescale 1ns/1ps
module evt_chan_regs import evt_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  logic        glb_en,
    input  logic        glb_rise,
    input  logic        glb_fall,
    input  logic        wr_cfg,
    input  logic        wr_cmp_lo,
    input  logic        wr_cmp_hi,
    input  logic        wr_rt_lo,
    input  logic        wr_rt_hi,
    input  logic [31:0] wdata,
    output logic [31:0] cfg_lo,
    output logic [63:0] cmp,
    output logic [63:0] route,
    output logic        armed
);
    logic [31:0] cfg_nxt;
    logic        m32;

    assign m32 = cfg_lo[CHB_M32];

    always_comb cfg_nxt = (cfg_lo & ~CH_CFG_WMASK) | (wdata & CH_CFG_WMASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_lo <= CH_CFG_RST;
            cmp    <= '1;
            route  <= '0;
            armed  <= 1'b0;
        end else begin
            if (wr_cfg) begin
                cfg_lo <= cfg_nxt;
                if (cfg_nxt[CHB_M32]) cmp[63:32] <= '0;
            end
            if (wr_cmp_lo) begin
                cmp[31:0]          <= wdata;
                cfg_lo[CHB_SETVAL] <= 1'b0;
            end
            if (wr_cmp_hi) begin
                if (!m32) cmp[63:32] <= wdata;
                cfg_lo[CHB_SETVAL] <= 1'b0;
            end
            if (wr_rt_lo) route[31:0]  <= wdata;
            if (wr_rt_hi) route[63:32] <= wdata;

            if (glb_fall)
                armed <= 1'b0;
            else if (glb_rise)
                armed <= (cmp != '1);
            else if (wr_cfg && cfg_nxt[CHB_ENA] && !cfg_lo[CHB_ENA])
                armed <= glb_en;
            else if (wr_cfg && !cfg_nxt[CHB_ENA] && cfg_lo[CHB_ENA])
                armed <= 1'b0;
            else if ((wr_cmp_lo || wr_cmp_hi) && glb_en)
                armed <= 1'b1;
        end
    end

    // R7: bits outside the write mask never move
    p_ro_bits_r7: assert property (@(posedge clk) disable iff (rst)
        $stable(cfg_lo & ~CH_CFG_WMASK));

    // R8: upper comparator half is zero in 32-bit mode
    p_m32_upper_r8: assert property (@(posedge clk) disable iff (rst)
        m32 |-> (cmp[63:32] == 32'd0));

    // R11: never armed while the counter is halted
    p_no_arm_halted_r11: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> !armed);
endmodule

// File: rtl/evtmr_regblk.sv
`timescale 1ns/1ps
module evtmr_regblk import evt_pkg::*; #(
    parameter int          N_CH      = 3,
    parameter logic [31:0] TICK_FS   = 32'd8_000_000,
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000,
    localparam int         NT        = clamp_ch(N_CH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NT-1:0]       evt_hit,
    output logic [CTR_W-1:0]    ctr_val,
    output logic                ctr_run,
    output logic                legacy_on,
    output logic [NT-1:0]       ch_armed,
    output logic [NT-1:0]       irq_sts,
    output logic [NT*32-1:0]    ch_cfg,
    output logic [NT*64-1:0]    ch_cmp,
    output logic [NT*64-1:0]    ch_route
);
    localparam logic [31:0] CAP_LO = CAP_LO_BASE | (32'(NT - 1) << CAP_NUM_LSB);

    dec_t        dec;
    logic [1:0]  gcfg;
    logic [NT-1:0] isr_q, isr_clr;
    logic        g_wr, g_rise, g_fall;
    logic [31:0] c_cfg [NT];
    logic [63:0] c_cmp [NT];
    logic [63:0] c_rt  [NT];
    logic [31:0] s_cfg;
    logic [63:0] s_cmp, s_rt;

    evt_addr_dec #(.NT(NT)) u_dec (.addr(bus_addr), .dec(dec));

    assign g_wr   = bus_wr && (dec.sel == REG_GCFG);
    assign g_rise = g_wr && bus_wdata[0] && !gcfg[0];
    assign g_fall = g_wr && !bus_wdata[0] && gcfg[0];

    always_ff @(posedge clk) begin
        if (rst)       gcfg <= 2'b00;
        else if (g_wr) gcfg <= bus_wdata[1:0];
    end

    assign isr_clr = (bus_wr && dec.sel == REG_ISR) ? bus_wdata[NT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= (isr_q & ~isr_clr) | evt_hit;
    end

    evt_main_ctr u_ctr (
        .clk   (clk),
        .rst   (rst),
        .run   (gcfg[0]),
        .wr_lo (bus_wr && dec.sel == REG_CTR_LO),
        .wr_hi (bus_wr && dec.sel == REG_CTR_HI),
        .wdata (bus_wdata),
        .cnt   (ctr_val)
    );

    for (genvar i = 0; i < NT; i++) begin : g_ch
        logic me;
        assign me = bus_wr && (dec.ch == 5'(i));
        evt_chan_regs u_ch (
            .clk       (clk),
            .rst       (rst),
            .glb_en    (gcfg[0]),
            .glb_rise  (g_rise),
            .glb_fall  (g_fall),
            .wr_cfg    (me && dec.sel == REG_CH_CFG_LO),
            .wr_cmp_lo (me && dec.sel == REG_CH_CMP_LO),
            .wr_cmp_hi (me && dec.sel == REG_CH_CMP_HI),
            .wr_rt_lo  (me && dec.sel == REG_CH_RT_LO),
            .wr_rt_hi  (me && dec.sel == REG_CH_RT_HI),
            .wdata     (bus_wdata),
            .cfg_lo    (c_cfg[i]),
            .cmp       (c_cmp[i]),
            .route     (c_rt[i]),
            .armed     (ch_armed[i])
        );
        assign ch_cfg[i*32 +: 32]   = c_cfg[i];
        assign ch_cmp[i*64 +: 64]   = c_cmp[i];
        assign ch_route[i*64 +: 64] = c_rt[i];
    end

    always_comb begin
        s_cfg = '0;
        s_cmp = '0;
        s_rt  = '0;
        for (int i = 0; i < NT; i++) begin
            if (dec.ch == 5'(i)) begin
                s_cfg = c_cfg[i];
                s_cmp = c_cmp[i];
                s_rt  = c_rt[i];
            end
        end
    end

    always_comb begin
        case (dec.sel)
            REG_CAP_LO:    bus_rdata = CAP_LO;
            REG_CAP_HI:    bus_rdata = TICK_FS;
            REG_GCFG:      bus_rdata = {30'd0, gcfg};
            REG_ISR:       bus_rdata = 32'(isr_q);
            REG_CTR_LO:    bus_rdata = ctr_val[31:0];
            REG_CTR_HI:    bus_rdata = ctr_val[63:32];
            REG_CH_CFG_LO: bus_rdata = s_cfg;
            REG_CH_CFG_HI: bus_rdata = ROUTE_CAP;
            REG_CH_CMP_LO: bus_rdata = s_cmp[31:0];
            REG_CH_CMP_HI: bus_rdata = s_cmp[63:32];
            REG_CH_RT_LO:  bus_rdata = s_rt[31:0];
            REG_CH_RT_HI:  bus_rdata = s_rt[63:32];
            default:       bus_rdata = 32'd0;
        endcase
    end

    assign ctr_run   = gcfg[0];
    assign legacy_on = gcfg[1];
    assign irq_sts   = isr_q;

    // R3: global configuration only moves on its own write
    p_gcfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !g_wr |=> $stable(gcfg));

    // R12: a hit always leaves its status bit set
    p_hit_sets_r12: assert property (@(posedge clk) disable iff (rst)
        evt_hit[0] |=> irq_sts[0]);

    // R12: write-one clears when no hit competes
    p_w1c_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.sel == REG_ISR && bus_wdata[0] && !evt_hit[0]) |=> !irq_sts[0]);

    // R11: a run edge to zero leaves nothing armed
    p_halt_disarm_r11: assert property (@(posedge clk) disable iff (rst)
        g_fall |=> (ch_armed == '0));
endmodule

// File: tb/evtmr_regblk_bench.sv
`timescale 1ns/1ps
module evtmr_regblk_bench;
    localparam logic [31:0] RCAP = 32'h00F0_0000;
    localparam int NT = 3;
    localparam int BT = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NT-1:0] evt_hit = '0;
    logic [63:0] ctr_val;
    logic        ctr_run, legacy_on;
    logic [NT-1:0] ch_armed, irq_sts;
    logic [NT*32-1:0] ch_cfg;
    logic [NT*64-1:0] ch_cmp, ch_route;

    logic [31:0] b_rdata;
    logic [63:0] b_ctr;
    logic        b_run, b_leg;
    logic [BT-1:0] b_arm, b_sts;
    logic [BT*32-1:0] b_cfg;
    logic [BT*64-1:0] b_cmp, b_rt;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    evtmr_regblk #(.N_CH(3), .TICK_FS(32'd8_000_000), .ROUTE_CAP(RCAP)) u_evtmr_regblk (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .evt_hit(evt_hit), .ctr_val(ctr_val), .ctr_run(ctr_run),
        .legacy_on(legacy_on), .ch_armed(ch_armed), .irq_sts(irq_sts), .ch_cfg(ch_cfg),
        .ch_cmp(ch_cmp), .ch_route(ch_route));

    evtmr_regblk #(.N_CH(40), .TICK_FS(32'd8_000_000), .ROUTE_CAP(RCAP)) u_evtmr_regblk_big (
        .clk(clk), .rst(rst), .bus_wr(1'b0), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(b_rdata), .evt_hit('0), .ctr_val(b_ctr), .ctr_run(b_run),
        .legacy_on(b_leg), .ch_armed(b_arm), .irq_sts(b_sts), .ch_cfg(b_cfg),
        .ch_cmp(b_cmp), .ch_route(b_rt));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // each write spans two rising edges; the second one performs the write
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h000, v); chk("R1 cap low", v, 32'h8086_A201);
        rd(12'h004, v); chk("R1 tick period", v, 32'd8_000_000);
        rd(12'h010, v); chk("R3 gcfg reset", v, 0);
        rd(12'h0F0, v); chk("R4 counter reset", v, 0);
        chk("R11 nothing armed at reset", ch_armed, 0);
    endtask

    task automatic t_clamp();
        logic [31:0] v;
        bus_addr = 12'h000; #1; chk("R2 clamped count in cap", b_rdata, 32'h8086_BF01);
        bus_addr = 12'h4E0; #1; chk("R2 last group present", b_rdata, 32'h30);
        bus_addr = 12'h500; #1; chk("R2 group past clamp reads 0", b_rdata, 0);
        rd(12'h160, v); chk("R2 group 3 absent", v, 0);
        wr(12'h168, 32'h0);
        rd(12'h108, v); chk("R2 write beyond count ignored ch0", v, 32'hFFFF_FFFF);
        rd(12'h148, v); chk("R2 write beyond count ignored ch2", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_gcfg();
        logic [31:0] v;
        wr(12'h010, 32'hFFFF_FFFE);
        rd(12'h010, v); chk("R3 only bits 1:0 kept", v, 32'h2);
        chk("R3 legacy output", legacy_on, 1);
        chk("R3 run output stays low", ctr_run, 0);
        wr(12'h010, 32'h0);
        rd(12'h010, v); chk("R3 cleared", v, 0);
    endtask

    task automatic t_counter();
        logic [31:0] v;
        logic [63:0] f;
        wr(12'h0F0, 32'hFFFF_FFF0);
        wr(12'h0F4, 32'h0000_0001);
        rd(12'h0F0, v); chk("R5 halted write low", v, 32'hFFFF_FFF0);
        rd(12'h0F4, v); chk("R5 halted write high", v, 32'h1);
        wr(12'h010, 32'h1);
        repeat (32) @(negedge clk);
        chk("R4 counts and carries", ctr_val, 64'h2_0000_0010);
        f = ctr_val;
        wr(12'h010, 32'h0);
        chk("R4 frozen value", ctr_val, f + 2);
        f = ctr_val;
        repeat (5) @(negedge clk);
        chk("R4 holds while halted", ctr_val, f);
        wr(12'h010, 32'h1);
        repeat (10) @(negedge clk);
        chk("R6 resumes from frozen value", ctr_val, f + 10);
        f = ctr_val;
        wr(12'h0F0, 32'h0000_0000);
        chk("R5 write ignored while running", ctr_val, f + 2);
        wr(12'h010, 32'h0);
    endtask

    task automatic t_chcfg();
        logic [31:0] v;
        rd(12'h100, v); chk("R7 cfg reset", v, 32'h30);
        rd(12'h104, v); chk("R7 cfg high reads route cap", v, RCAP);
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, v); chk("R7 masked write", v, 32'h7F7E);
        rd(12'h10C, v); chk("R8 32-bit mode zeroes high", v, 0);
        rd(12'h108, v); chk("R8 low half kept", v, 32'hFFFF_FFFF);
        wr(12'h10C, 32'h1234);
        rd(12'h10C, v); chk("R8 high write ignored in 32-bit mode", v, 0);
        wr(12'h104, 32'hFFFF_FFFF);
        rd(12'h104, v); chk("R7 cfg high write ignored", v, RCAP);
        wr(12'h100, 32'h0);
        rd(12'h100, v); chk("R7 clear writable bits", v, 32'h30);
        wr(12'h100, 32'h40);
        rd(12'h100, v); chk("R8 bit 6 set", v, 32'h70);
        wr(12'h108, 32'h55);
        rd(12'h100, v); chk("R8 comparator write clears bit 6", v, 32'h30);
        rd(12'h108, v); chk("R8 comparator low", v, 32'h55);
        wr(12'h10C, 32'h9);
        rd(12'h10C, v); chk("R8 comparator high", v, 32'h9);
        chk("R8 comparator port", ch_cmp[63:0], 64'h9_0000_0055);
        chk("R11 comparator write while halted does not arm", ch_armed, 0);
    endtask

    task automatic t_route();
        logic [31:0] v;
        rd(12'h130, v); chk("R9 route reset", v, 0);
        wr(12'h130, 32'hDEAD_BEEF);
        wr(12'h134, 32'hCAFE_0001);
        rd(12'h130, v); chk("R9 route low", v, 32'hDEAD_BEEF);
        rd(12'h134, v); chk("R9 route high", v, 32'hCAFE_0001);
        chk("R9 route port", ch_route[127:64], 64'hCAFE_0001_DEAD_BEEF);
    endtask

    task automatic t_arm();
        wr(12'h010, 32'h1);
        chk("R10 only programmed channel arms", ch_armed, 3'b001);
        wr(12'h120, 32'h4);
        chk("R11 enable bit rise arms", ch_armed, 3'b011);
        wr(12'h120, 32'h0);
        chk("R11 enable bit fall disarms", ch_armed, 3'b001);
        wr(12'h148, 32'h10);
        chk("R11 comparator write while running arms", ch_armed, 3'b101);
        wr(12'h010, 32'h0);
        chk("R11 halt disarms all", ch_armed, 3'b000);
        wr(12'h010, 32'h1);
        chk("R10 re-arm programmed channels", ch_armed, 3'b101);
        wr(12'h010, 32'h0);
    endtask

    task automatic t_isr();
        logic [31:0] v;
        @(negedge clk); evt_hit = 3'b010;
        @(negedge clk); evt_hit = 3'b000;
        rd(12'h020, v); chk("R12 hit sets bit", v, 32'h2);
        wr(12'h020, 32'h1);
        rd(12'h020, v); chk("R12 writing 0 keeps bit", v, 32'h2);
        wr(12'h020, 32'h2);
        rd(12'h020, v); chk("R12 write 1 clears", v, 0);
        evt_hit = 3'b001;
        wr(12'h020, 32'h1);
        evt_hit = 3'b000;
        chk("R12 hit wins over clear", irq_sts, 3'b001);
        wr(12'h020, 32'h1);
        chk("R12 cleared after", irq_sts, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(12'h030, v); chk("R13 unmapped reads 0", v, 0);
        rd(12'h0F8, v); chk("R13 unmapped near counter", v, 0);
        rd(12'h014, v); chk("R13 gcfg high reads 0", v, 0);
        rd(12'h002, v); chk("R13 misaligned read", v, 0);
        wr(12'h011, 32'h1);
        chk("R13 misaligned write ignored", ctr_run, 0);
        wr(12'h030, 32'hFFFF_FFFF);
        rd(12'h010, v); chk("R13 unmapped write no effect", v, 0);
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_clamp();
        t_gcfg();
        t_counter();
        t_chcfg();
        t_route();
        t_arm();
        t_isr();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule